// File: doc/BRIEF.md
# Periodic Trigger Pulse Generator

This block produces a trigger pulse at a programmed interval, measured on a free-running clock whose every cycle stands for 8 ns. Software programs a 32-bit cycle count, split over two 16-bit registers, and a picosecond correction term. A fractional accumulator collects the correction once per period. Each time it passes one whole tick, that period is stretched by one clock. The average spacing between pulses can therefore be set more finely than one clock, as a pulse-per-second source needs.

A configuration register holds three controls: run/stop, single-shot versus repeating operation, and output polarity. The pulse drives a pin output, where polarity applies, and an internal event strobe, which is always active-high. Writes use a simple one-cycle strobe. Reads are combinational.

Top module: `trig_pulse_gen`

## Requirements
- R1: After reset every register reads zero, `trig_out` is low and `trig_event` is low.
- R2: Address 0 is the control register, with bit 0 run, bit 1 single-shot and bit 12 active-low output; all other control bits read as zero. Address 1 holds the low 16 bits of the cycle count, address 2 the high 16 bits, and address 3 the picosecond correction. Every register reads back what was last written to it.
- R3: When a write sets the run bit while the generator is stopped, the first `trig_event` pulse is high in the cycle that follows the P-th rising edge after the edge that took the write, where P is the programmed count.
- R4: While running in repeating mode, `trig_event` pulses recur every P cycles, each pulse one cycle wide.
- R5: Each period adds the correction to an accumulator, which is cleared when the generator is started. When the sum reaches 8000, that period lasts P+1 cycles and 8000 is taken off the sum. A correction of 8000 or more is used as 7999.
- R6: A count written while running leaves the current period alone and sets the length of the periods after the next pulse.
- R7: In single-shot mode the generator gives one pulse, one period after the start, and then clears its own run bit, so the control register reads back with bit 0 at zero.
- R8: `trig_out` equals `trig_event`, inverted when the active-low bit is set, so the idle level is high in active-low mode.
- R9: Clearing the run bit stops the pulses. No pulse appears while the generator is stopped.
- R10: A programmed count of zero is treated as one, so a pulse appears every cycle.
- R11: Writing the run bit as one while the generator is already running does not restart the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-base clock, one 8 ns tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | DATA_W | Combinational read data |
| trig_out | output | 1 | Trigger pulse for a pin, polarity applied |
| trig_event | output | 1 | Active-high trigger strobe for internal use |

## Verification
A write takes effect on the clock edge that samples it. The first pulse then comes P edges later, plus one edge for each correction carry, and later pulses come at each reload edge. The bench keeps a cycle counter that advances at every rising edge and stamps each pulse it sees on the falling edge. It works out every expected stamp from the write edge, the count and a picosecond sum that it models itself, and compares them. Pulses are counted only after two idle cycles have passed, so a pulse fired on the stopping edge itself is never missed.

// File: rtl/trig_pkg.sv
package trig_pkg;

   // control register bit positions
   localparam int CFG_RUN_BIT    = 0;
   localparam int CFG_SHOT_BIT   = 1;
   localparam int CFG_ACTLO_BIT  = 12;

   // register addresses; count halves follow the base address in order
   localparam int CFG_ADDR  = 0;
   localparam int CNT_BASE  = 1;

   typedef struct packed {
      logic active_low;
      logic one_shot;
      logic run;
   } trig_cfg_t;

endpackage

// File: rtl/trig_regs.sv
module trig_regs
   import trig_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 32,
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              clr_run,
   output trig_cfg_t         cfg,
   output logic              start,
   output logic [CNT_W-1:0]  period,
   output logic [DATA_W-1:0] comp
);

   localparam int N_HALF    = CNT_W / DATA_W;
   localparam int COMP_ADDR = CNT_BASE + N_HALF;

   logic              run_q, shot_q, actlo_q;
   logic [DATA_W-1:0] cnt_q [N_HALF];
   logic [DATA_W-1:0] comp_q;
   logic              wr_cfg;

   assign wr_cfg = wr_en && (wr_addr == ADDR_W'(CFG_ADDR));
   assign start  = wr_cfg && wr_data[CFG_RUN_BIT] && !run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         shot_q  <= 1'b0;
         actlo_q <= 1'b0;
      end else if (wr_cfg) begin
         run_q   <= wr_data[CFG_RUN_BIT];
         shot_q  <= wr_data[CFG_SHOT_BIT];
         actlo_q <= wr_data[CFG_ACTLO_BIT];
      end else if (clr_run) begin
         run_q   <= 1'b0;
      end
   end

   for (genvar h = 0; h < N_HALF; h++) begin : g_half
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cnt_q[h] <= '0;
         else if (wr_en && (wr_addr == ADDR_W'(CNT_BASE + h)))
            cnt_q[h] <= wr_data;
      end
      assign period[h*DATA_W +: DATA_W] = cnt_q[h];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         comp_q <= '0;
      else if (wr_en && (wr_addr == ADDR_W'(COMP_ADDR)))
         comp_q <= wr_data;
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == ADDR_W'(CFG_ADDR)) begin
         rd_data[CFG_RUN_BIT]   = run_q;
         rd_data[CFG_SHOT_BIT]  = shot_q;
         rd_data[CFG_ACTLO_BIT] = actlo_q;
      end
      for (int h = 0; h < N_HALF; h++)
         if (rd_addr == ADDR_W'(CNT_BASE + h))
            rd_data = cnt_q[h];
      if (rd_addr == ADDR_W'(COMP_ADDR))
         rd_data = comp_q;
   end

   assign cfg.run        = run_q;
   assign cfg.one_shot   = shot_q;
   assign cfg.active_low = actlo_q;
   assign comp           = comp_q;

   // single-shot completion must drop the run bit unless software rewrites it
   assert_shot_clears_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_run && !wr_cfg) |=> !run_q);

endmodule

// File: rtl/trig_comp.sv
module trig_comp #(
   parameter int DATA_W  = 16,
   parameter int TICK_PS = 8000,
   parameter bit COMP_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              advance,
   input  logic [DATA_W-1:0] comp_in,
   output logic              extra
);

   localparam int ACC_W = $clog2(2 * TICK_PS);

   if (COMP_EN) begin : g_comp
      logic [ACC_W-1:0] acc_q;
      logic [ACC_W-1:0] comp_eff;
      logic [ACC_W-1:0] sum;

      always_comb begin
         if (comp_in >= DATA_W'(TICK_PS))
            comp_eff = ACC_W'(TICK_PS - 1);
         else
            comp_eff = ACC_W'(comp_in);
         sum   = (start ? '0 : acc_q) + comp_eff;
         extra = (sum >= ACC_W'(TICK_PS));
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            acc_q <= '0;
         else if (start || advance)
            acc_q <= extra ? (sum - ACC_W'(TICK_PS)) : sum;
      end

      // the remainder kept between periods is always below one tick
      assert_acc_below_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
         acc_q < ACC_W'(TICK_PS));
   end else begin : g_nocomp
      assign extra = 1'b0;
   end

endmodule

// File: rtl/trig_timer.sv
module trig_timer #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             run,
   input  logic             one_shot,
   input  logic [CNT_W-1:0] period,
   input  logic             extra,
   output logic             advance,
   output logic             clr_run,
   output logic             pulse
);

   localparam int LEN_W = CNT_W + 1;

   logic [LEN_W-1:0] len;
   logic [LEN_W-1:0] rem_q;
   logic             pulse_q;

   always_comb begin
      len = ((period == '0) ? LEN_W'(1) : {1'b0, period}) + LEN_W'(extra);
   end

   assign advance = run && !start && (rem_q == '0);
   assign clr_run = advance && one_shot;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q   <= '0;
         pulse_q <= 1'b0;
      end else if (start) begin
         rem_q   <= len - LEN_W'(1);
         pulse_q <= 1'b0;
      end else if (!run) begin
         pulse_q <= 1'b0;
      end else if (rem_q == '0) begin
         rem_q   <= len - LEN_W'(1);
         pulse_q <= 1'b1;
      end else begin
         rem_q   <= rem_q - LEN_W'(1);
         pulse_q <= 1'b0;
      end
   end

   assign pulse = pulse_q;

   // a pulse can only follow a cycle in which the generator was running
   assert_pulse_needs_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |-> $past(run));

   // starting never yields a pulse on the next cycle
   assert_start_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !pulse_q);

endmodule

// File: rtl/trig_pulse_gen.sv
module trig_pulse_gen
   import trig_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int CNT_W   = 32,
   parameter int ADDR_W  = 2,
   parameter int TICK_PS = 8000,
   parameter bit COMP_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              trig_out,
   output logic              trig_event
);

   localparam int N_HALF = CNT_W / DATA_W;

   if (CNT_W % DATA_W != 0) begin : g_bad_split
      $error("CNT_W must be a multiple of DATA_W");
   end
   if (DATA_W <= CFG_ACTLO_BIT) begin : g_bad_data
      $error("DATA_W too narrow for the control bits");
   end
   if ((1 << ADDR_W) < N_HALF + 2) begin : g_bad_addr
      $error("ADDR_W cannot reach every register");
   end
   if (TICK_PS >= (1 << DATA_W)) begin : g_bad_tick
      $error("TICK_PS does not fit in DATA_W");
   end

   trig_cfg_t         cfg;
   logic              start, advance, clr_run, extra, pulse;
   logic [CNT_W-1:0]  period;
   logic [DATA_W-1:0] comp;

   trig_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .clr_run (clr_run),
      .cfg     (cfg),
      .start   (start),
      .period  (period),
      .comp    (comp)
   );

   trig_comp #(.DATA_W(DATA_W), .TICK_PS(TICK_PS), .COMP_EN(COMP_EN)) u_comp (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .advance (advance),
      .comp_in (comp),
      .extra   (extra)
   );

   trig_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .run      (cfg.run),
      .one_shot (cfg.one_shot),
      .period   (period),
      .extra    (extra),
      .advance  (advance),
      .clr_run  (clr_run),
      .pulse    (pulse)
   );

   assign trig_event = pulse;
   assign trig_out   = pulse ^ cfg.active_low;

endmodule

// File: tb/trig_pulse_gen_test.sv
module trig_pulse_gen_test;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [1:0]  rd_addr = '0;
   logic [15:0] rd_data;
   logic        trig_out, trig_event;

   int cyc = 0;
   int ptotal = 0;
   int ptime [64];
   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   trig_pulse_gen uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .trig_out(trig_out), .trig_event(trig_event)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (trig_event) begin
         ptime[ptotal % 64] = cyc;
         ptotal = ptotal + 1;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails = fails + 1;
         tests = tests + 1;
         $display("FAIL watchdog: actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests = tests + 1;
      if (!ok) begin
         fails = fails + 1;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // called at a falling edge; the write lands on the next rising edge
   task automatic wr(input int a, input int d, output int edge_no);
      wr_en = 1'b1; wr_addr = 2'(a); wr_data = 16'(d);
      @(negedge clk);
      wr_en = 1'b0;
      edge_no = cyc;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic rd(input int a, output int v);
      rd_addr = 2'(a);
      #1;
      v = int'(rd_data);
   endtask

   task automatic set_count(input int p, input int c);
      int e;
      wr(1, p & 16'hFFFF, e);
      wr(2, (p >> 16) & 16'hFFFF, e);
      wr(3, c, e);
   endtask

   // runs a repeating train and compares every pulse stamp with the model
   task automatic run_train(input int p, input int c, input int win, input string req);
      int w, d, base, got, n, acc, t, len, cc, first_bad, act_bad, exp_bad;
      int expt [64];
      set_count(p, c);
      base = ptotal;
      wr(0, 1, w);
      idle(win);
      wr(0, 0, d);
      idle(2);
      cc  = (c >= 8000) ? 7999 : c;
      len = (p == 0) ? 1 : p;
      acc = 0; t = w; n = 0;
      while (n < 64) begin
         acc = acc + cc;
         if (acc >= 8000) begin
            acc = acc - 8000;
            t = t + len + 1;
         end else begin
            t = t + len;
         end
         if (t > d) break;
         expt[n] = t;
         n = n + 1;
      end
      got = ptotal - base;
      chk(got == n, req, got, n);
      // R3: first pulse P edges after the enabling edge
      chk(got >= 1 && ptime[base % 64] == expt[0], "R3 first pulse",
          (got >= 1) ? ptime[base % 64] - w : -1, expt[0] - w);
      first_bad = -1; act_bad = 0; exp_bad = 0;
      for (int i = 0; i < n && i < got; i++) begin
         if (first_bad < 0 && ptime[(base + i) % 64] != expt[i]) begin
            first_bad = i;
            act_bad = ptime[(base + i) % 64] - w;
            exp_bad = expt[i] - w;
         end
      end
      chk(first_bad < 0, req, act_bad, exp_bad);
   endtask

   initial begin
      int v, w, d, base, snap, got, t;
      int comps [4] = '{1000, 4000, 7999, 12000};

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle(1);

      // R1: reset state
      chk(trig_out == 1'b0, "R1 trig_out", int'(trig_out), 0);
      chk(trig_event == 1'b0, "R1 trig_event", int'(trig_event), 0);
      for (int a = 0; a < 4; a++) begin
         rd(a, v);
         chk(v == 0, "R1 readback", v, 0);
      end

      // R2: register map and readback
      wr(0, 16'hFFFE, w);
      rd(0, v); chk(v == 16'h1002, "R2 control", v, 16'h1002);
      wr(1, 16'hA5A5, w);
      wr(2, 16'h5A5A, w);
      wr(3, 16'h1234, w);
      rd(1, v); chk(v == 16'hA5A5, "R2 count low", v, 16'hA5A5);
      rd(2, v); chk(v == 16'h5A5A, "R2 count high", v, 16'h5A5A);
      rd(3, v); chk(v == 16'h1234, "R2 correction", v, 16'h1234);
      wr(0, 0, w);

      // R4: period sweep without correction
      for (int p = 1; p <= 6; p++) run_train(p, 0, 30, "R4 period sweep");

      // R10: zero count acts as one
      run_train(0, 0, 20, "R10 zero count");

      // R5: correction sweep, including a saturated value
      foreach (comps[k]) run_train(3, comps[k], 60, "R5 correction");

      // R8: polarity
      set_count(3, 0);
      wr(0, 16'h1000, w);
      chk(trig_out == 1'b1, "R8 idle high", int'(trig_out), 1);
      wr(0, 16'h1001, w);
      idle(2);
      chk(trig_out == 1'b1, "R8 before pulse", int'(trig_out), 1);
      idle(1);
      chk(trig_out == 1'b0 && trig_event == 1'b1, "R8 active low pulse", int'(trig_out), 0);
      idle(1);
      chk(trig_out == 1'b1, "R8 after pulse", int'(trig_out), 1);
      wr(0, 0, w);
      idle(1);
      chk(trig_out == 1'b0, "R8 back to active high", int'(trig_out), 0);

      // R6: count change while running
      set_count(5, 0);
      base = ptotal;
      wr(0, 1, w);
      idle(6);
      wr(1, 2, v);
      idle(12);
      wr(0, 0, d);
      idle(2);
      got = ptotal - base;
      chk(got == 7, "R6 pulse count", got, 7);
      t = w + 5;
      for (int i = 0; i < 7 && i < got; i++) begin
         chk(ptime[(base + i) % 64] == t, "R6 pulse time", ptime[(base + i) % 64] - w, t - w);
         t = t + ((i == 0) ? 5 : 2);
      end

      // R11: rewriting run while running keeps the phase
      set_count(4, 0);
      base = ptotal;
      wr(0, 1, w);
      idle(1);
      wr(0, 1, v);
      idle(13);
      wr(0, 0, d);
      idle(2);
      got = ptotal - base;
      chk(got == 4, "R11 pulse count", got, 4);
      for (int i = 0; i < 4 && i < got; i++)
         chk(ptime[(base + i) % 64] == w + 4 * (i + 1), "R11 pulse time",
             ptime[(base + i) % 64] - w, 4 * (i + 1));

      // R7: single shot
      set_count(4, 0);
      base = ptotal;
      wr(0, 3, w);
      idle(20);
      got = ptotal - base;
      chk(got == 1, "R7 single pulse", got, 1);
      chk(got >= 1 && ptime[base % 64] == w + 4, "R7 pulse time",
          (got >= 1) ? ptime[base % 64] - w : -1, 4);
      rd(0, v); chk(v == 2, "R7 run bit cleared", v, 2);
      wr(0, 0, w);

      // R9: stopping ends the train
      set_count(2, 0);
      wr(0, 1, w);
      idle(9);
      wr(0, 0, d);
      idle(2);
      snap = ptotal;
      idle(20);
      chk(ptotal == snap, "R9 quiet after stop", ptotal - snap, 0);
      chk(trig_event == 1'b0, "R9 event low", int'(trig_event), 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule